// File: doc/BRIEF.md
# Dual-Channel Hot-Swap Power Sequencer

This block is the digital controller for two hot-plug power paths on a plug-in card. Each path has an external pass switch. Analog circuits report, as synchronous digital flags, whether the channel's input is above its undervoltage level and below its overvoltage level, whether its enable is asserted, whether the current limiter is regulating, whether the sense voltage is above the breaker level, and whether the output has reached power-good. From these flags the block decides when to drive each channel's gate enable. It also qualifies the power-good output and raises an overcurrent fault.

A channel must see its supply and enable conditions stay valid for a debounce interval before it may turn on. An effective ON control then releases it. This control comes from a shared ON pin, unless a per-channel register bit overrides the pin. A start-up window follows. During this window the breaker is disarmed and power-good is hidden. If the limiter is still regulating when the window ends, the channel faults. After start-up, an over-threshold current that lasts for the breaker timeout trips the channel.

Every overcurrent fault starts a shared cool-down of a fixed multiple of the start-up window. No channel may start during the cool-down. When it ends, a faulted channel either retries or stays latched off. In coupled mode the two channels start together and trip together. In independent mode they run separately, with two interactions: a late arrival restarts a running debounce, and no channel starts while the other is in start-up.

Top module: `hot_pair_seq`

## Requirements
- R1: While rst_n is low and on the first cycle after it, gate_en, pg_out and oc_fault are all zero.
- R2: A channel's gate_en rises exactly DEB_TICKS+1 clock edges after uv_ok, ov_ok and en_in all become 1 (ON already high, no interaction). A drop of any of these before that point starts the count again.
- R3: The effective ON control of channel i is reg_on_val[i] when reg_on_sel[i] is 1, and on_pin otherwise. A debounced channel waits while the control is 0 and starts on the next edge after it becomes 1. A 0 during start-up or on turns the gate off.
- R4: In independent mode (couple_mode=0), if one channel enters debounce while the other is still debouncing, the other's debounce restarts and both gates rise on the same edge.
- R5: In independent mode, a debounced channel does not start while the other channel is in its start-up window. It starts on the edge after that window ends.
- R6: The start-up window lasts START_TICKS cycles. pg_out stays 0 throughout. If ilim_act is 1 at the window's last edge, the gate turns off and oc_fault is set.
- R7: After start-up, pg_out follows pg_in. An overcurrent fault is raised only when brk_over is 1 on BRK_TICKS consecutive edges. Shorter bursts are ignored.
- R8: In coupled mode (couple_mode=1), neither channel starts until both have debounced. A fault on either channel turns both gates off, and oc_fault is set only for the faulting channel.
- R9: In independent mode, a fault on one channel leaves the other channel's gate on.
- R10: After any fault, no gate rises for COOL_MULT*START_TICKS cycles. A channel with retry_en=1 then restarts through debounce.
- R11: Taking a faulted channel's ON control low during cool-down ends the cool-down at once. Toggling en_in, uv_ok or ov_ok does not.
- R12: With retry_en=0, a faulted channel stays off after cool-down whatever its supply and enable inputs do. It leaves this state only when its ON control goes low, and it then restarts through debounce when the control is high. oc_fault clears when it leaves.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| on_pin | input | 1 | Shared ON control pin |
| couple_mode | input | 1 | 1 = channels coupled, 0 = independent |
| uv_ok | input | 2 | Per channel: supply above undervoltage level |
| ov_ok | input | 2 | Per channel: supply below overvoltage level |
| en_in | input | 2 | Per channel: card enable asserted |
| ilim_act | input | 2 | Per channel: current limiter regulating |
| brk_over | input | 2 | Per channel: sense voltage above breaker level |
| pg_in | input | 2 | Per channel: output at power-good level |
| reg_on_sel | input | 2 | Per channel: register ON bit overrides the pin |
| reg_on_val | input | 2 | Per channel: register ON value |
| retry_en | input | 2 | Per channel: auto-retry after cool-down |
| gate_en | output | 2 | Per channel: pass switch gate enable |
| pg_out | output | 2 | Per channel: qualified power-good |
| oc_fault | output | 2 | Per channel: overcurrent fault flag |

## Verification
The assertions assume that every input is already synchronous to clk. They also assume that couple_mode changes only while both channels are off, because the coupled-trip and start-blocking properties read the mode on the cycle they fire. The stimulus drives all inputs on the falling edge and changes couple_mode only right after a reset. Random breaker burst lengths are chosen around BRK_TICKS, and the trip outcome is predicted by a bench function.

// File: rtl/hps_pkg.sv
// Shared types for the dual hot-swap sequencer.
// Assumes: nothing; pure declarations.
package hps_pkg;
    typedef enum logic [2:0] {
        CH_OFF   = 3'd0,
        CH_DEB   = 3'd1,
        CH_START = 3'd2,
        CH_ON    = 3'd3,
        CH_COOL  = 3'd4,
        CH_LATCH = 3'd5
    } ch_state_t;
endpackage

// File: rtl/hps_cool.sv
// Shared cool-down timer: loads on any trip, counts down, can be cleared
// by an ON bypass. Assumes load_i and clear_i are synchronous pulses.
module hps_cool #(
    parameter int COOL_TICKS = 1000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic load_i,
    input  logic clear_i,
    output logic busy_o
);
    localparam int CW = $clog2(COOL_TICKS + 1);
    localparam logic [CW-1:0] COOL_LD = CW'(COOL_TICKS);

    logic [CW-1:0] cnt_q;

    // Countdown register; a trip has priority over a bypass clear.
    always_ff @(posedge clk) begin
        if (!rst_n)             cnt_q <= '0;
        else if (load_i)        cnt_q <= COOL_LD;
        else if (clear_i)       cnt_q <= '0;
        else if (cnt_q != '0)   cnt_q <= cnt_q - 1'b1;
    end

    assign busy_o = (cnt_q != '0);

    p_cool_load_r10: assert property (@(posedge clk) disable iff (!rst_n)
        load_i |=> busy_o);
endmodule

// File: rtl/hps_chan.sv
// One hot-swap channel: debounce, start-up window, breaker timer and fault
// handling, all sharing one down-counter. Assumes all inputs synchronous and
// that start_ok_i / partner_trip_i come from the pair-level arbitration.
module hps_chan
    import hps_pkg::*;
#(
    parameter int DEB_TICKS   = 8,
    parameter int START_TICKS = 20,
    parameter int BRK_TICKS   = 4
) (
    input  logic      clk,
    input  logic      rst_n,
    input  logic      cond_i,
    input  logic      on_i,
    input  logic      ilim_i,
    input  logic      brk_i,
    input  logic      pg_i,
    input  logic      start_ok_i,
    input  logic      deb_restart_i,
    input  logic      partner_trip_i,
    input  logic      cool_busy_i,
    input  logic      retry_i,
    output ch_state_t state_o,
    output logic      deb_done_o,
    output logic      entering_o,
    output logic      trip_o,
    output logic      bypass_o,
    output logic      gate_o,
    output logic      pg_o,
    output logic      flt_o
);
    localparam int MAXT = (DEB_TICKS > START_TICKS)
                          ? ((DEB_TICKS > BRK_TICKS) ? DEB_TICKS : BRK_TICKS)
                          : ((START_TICKS > BRK_TICKS) ? START_TICKS : BRK_TICKS);
    localparam int TW = $clog2(MAXT + 1);
    localparam logic [TW-1:0] DEB_LD   = TW'(DEB_TICKS - 1);
    localparam logic [TW-1:0] START_LD = TW'(START_TICKS - 1);
    localparam logic [TW-1:0] BRK_LD   = TW'(BRK_TICKS - 1);

    ch_state_t     st_q, st_d;
    logic [TW-1:0] t_q, t_d;
    logic          flt_q, flt_d;

    // Next-state, timer and trip decode for the channel.
    always_comb begin
        st_d   = st_q;
        t_d    = t_q;
        trip_o = 1'b0;
        case (st_q)
            CH_OFF: if (cond_i) begin
                st_d = CH_DEB;
                t_d  = DEB_LD;
            end
            CH_DEB: begin
                if (!cond_i)                          st_d = CH_OFF;
                else if (deb_restart_i && t_q != '0)  t_d  = DEB_LD;
                else if (t_q != '0)                   t_d  = t_q - 1'b1;
                else if (on_i && start_ok_i) begin
                    st_d = CH_START;
                    t_d  = START_LD;
                end
            end
            CH_START: begin
                if (!cond_i || !on_i)  st_d = CH_OFF;
                else if (t_q != '0)    t_d  = t_q - 1'b1;
                else if (ilim_i) begin
                    trip_o = 1'b1;
                    st_d   = CH_COOL;
                end else begin
                    st_d = CH_ON;
                    t_d  = BRK_LD;
                end
            end
            CH_ON: begin
                if (!cond_i || !on_i)  st_d = CH_OFF;
                else if (!brk_i)       t_d  = BRK_LD;
                else if (t_q != '0)    t_d  = t_q - 1'b1;
                else begin
                    trip_o = 1'b1;
                    st_d   = CH_COOL;
                end
            end
            CH_COOL: begin
                if (!on_i)             st_d = CH_OFF;
                else if (!cool_busy_i) st_d = retry_i ? CH_OFF : CH_LATCH;
            end
            CH_LATCH: if (!on_i) st_d = CH_OFF;
            default: st_d = CH_OFF;
        endcase
        if (partner_trip_i && st_q != CH_COOL && st_q != CH_LATCH)
            st_d = CH_COOL;
        flt_d = trip_o ? 1'b1 : ((st_d == CH_OFF) ? 1'b0 : flt_q);
    end

    // State, timer and fault flag registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q  <= CH_OFF;
            t_q   <= '0;
            flt_q <= 1'b0;
        end else begin
            st_q  <= st_d;
            t_q   <= t_d;
            flt_q <= flt_d;
        end
    end

    assign state_o    = st_q;
    assign deb_done_o = (st_q == CH_DEB) && (t_q == '0);
    assign entering_o = (st_q == CH_OFF) && cond_i;
    assign bypass_o   = (st_q == CH_COOL) && !on_i;
    assign gate_o     = (st_q == CH_START) || (st_q == CH_ON);
    assign pg_o       = (st_q == CH_ON) && pg_i;
    assign flt_o      = flt_q;

    p_start_cond_r2: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(gate_o) |-> $past(cond_i) && $past(on_i) && $past(start_ok_i));
    p_trip_off_r6: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(flt_o) |-> !gate_o);
    p_pg_gate_r7: assert property (@(posedge clk) disable iff (!rst_n)
        pg_o |-> gate_o && pg_i);
    p_latch_hold_r12: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == CH_LATCH && on_i) |=> !gate_o);
endmodule

// File: rtl/hot_pair_seq.sv
// Pair-level sequencer: derives each channel's ON control, arbitrates
// coupled/independent starts, shares the cool-down timer and propagates
// coupled trips. Assumes couple_mode changes only while both channels are off.
module hot_pair_seq
    import hps_pkg::*;
#(
    parameter int DEB_TICKS   = 12_500_000,
    parameter int START_TICKS = 12_500_000,
    parameter int BRK_TICKS   = 2_500,
    parameter int COOL_MULT   = 50
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       on_pin,
    input  logic       couple_mode,
    input  logic [1:0] uv_ok,
    input  logic [1:0] ov_ok,
    input  logic [1:0] en_in,
    input  logic [1:0] ilim_act,
    input  logic [1:0] brk_over,
    input  logic [1:0] pg_in,
    input  logic [1:0] reg_on_sel,
    input  logic [1:0] reg_on_val,
    input  logic [1:0] retry_en,
    output logic [1:0] gate_en,
    output logic [1:0] pg_out,
    output logic [1:0] oc_fault
);
    localparam int COOL_TICKS = COOL_MULT * START_TICKS;

    ch_state_t  st [2];
    logic [1:0] on_ctl, start_ok, deb_restart, partner_trip;
    logic [1:0] deb_done, entering, trip, bypass;
    logic       cool_busy;

    for (genvar i = 0; i < 2; i++) begin : g_ch
        localparam int J = 1 - i;

        // Per-channel ON source select and pair arbitration.
        always_comb begin
            on_ctl[i]       = reg_on_sel[i] ? reg_on_val[i] : on_pin;
            start_ok[i]     = !cool_busy &&
                              (couple_mode ? (deb_done[J] && on_ctl[J])
                                           : (st[J] != CH_START));
            deb_restart[i]  = entering[J];
            partner_trip[i] = couple_mode && trip[J];
        end

        hps_chan #(
            .DEB_TICKS  (DEB_TICKS),
            .START_TICKS(START_TICKS),
            .BRK_TICKS  (BRK_TICKS)
        ) u_chan (
            .clk           (clk),
            .rst_n         (rst_n),
            .cond_i        (uv_ok[i] && ov_ok[i] && en_in[i]),
            .on_i          (on_ctl[i]),
            .ilim_i        (ilim_act[i]),
            .brk_i         (brk_over[i]),
            .pg_i          (pg_in[i]),
            .start_ok_i    (start_ok[i]),
            .deb_restart_i (deb_restart[i]),
            .partner_trip_i(partner_trip[i]),
            .cool_busy_i   (cool_busy),
            .retry_i       (retry_en[i]),
            .state_o       (st[i]),
            .deb_done_o    (deb_done[i]),
            .entering_o    (entering[i]),
            .trip_o        (trip[i]),
            .bypass_o      (bypass[i]),
            .gate_o        (gate_en[i]),
            .pg_o          (pg_out[i]),
            .flt_o         (oc_fault[i])
        );
    end

    hps_cool #(.COOL_TICKS(COOL_TICKS)) u_cool (
        .clk    (clk),
        .rst_n  (rst_n),
        .load_i (|trip),
        .clear_i(|bypass),
        .busy_o (cool_busy)
    );

    p_couple_trip_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (couple_mode && (|trip)) |=> (gate_en == 2'b00));
    p_cool_block_r10: assert property (@(posedge clk) disable iff (!rst_n)
        cool_busy |=> !$rose(gate_en[0]) && !$rose(gate_en[1]));
    p_indep_block_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (!couple_mode && st[1] == CH_START && st[0] == CH_DEB) |=> (st[0] != CH_START));
endmodule

// File: tb/hot_pair_seq_tb_top.sv
`timescale 1ns/1ps
module hot_pair_seq_tb_top;
    localparam int DEB   = 8;
    localparam int START = 20;
    localparam int BRK   = 4;
    localparam int MULT  = 50;
    localparam int COOL  = MULT * START;

    logic       clk = 1'b0;
    logic       rst_n;
    logic       on_pin, couple_mode;
    logic [1:0] uv_ok, ov_ok, en_in, ilim_act, brk_over, pg_in;
    logic [1:0] reg_on_sel, reg_on_val, retry_en;
    logic [1:0] gate_en, pg_out, oc_fault;

    int n_tests = 0;
    int n_fail  = 0;
    bit done    = 1'b0;

    always #4 clk = ~clk;

    hot_pair_seq #(.DEB_TICKS(DEB), .START_TICKS(START), .BRK_TICKS(BRK),
                   .COOL_MULT(MULT)) dut_i (
        .clk(clk), .rst_n(rst_n), .on_pin(on_pin), .couple_mode(couple_mode),
        .uv_ok(uv_ok), .ov_ok(ov_ok), .en_in(en_in), .ilim_act(ilim_act),
        .brk_over(brk_over), .pg_in(pg_in), .reg_on_sel(reg_on_sel),
        .reg_on_val(reg_on_val), .retry_en(retry_en), .gate_en(gate_en),
        .pg_out(pg_out), .oc_fault(oc_fault));

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic check(input string tag, input int act, input int exp);
        n_tests++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    function automatic int exp_trip(input int k);
        return (k >= BRK) ? 1 : 0;
    endfunction

    task automatic do_reset();
        rst_n = 1'b0; on_pin = 1'b0; couple_mode = 1'b0;
        uv_ok = '0; ov_ok = '0; en_in = '0; ilim_act = '0; brk_over = '0;
        pg_in = '0; reg_on_sel = '0; reg_on_val = '0; retry_en = '0;
        tick(3);
        rst_n = 1'b1;
        tick(1);
    endtask

    task automatic raise(input int ch);
        uv_ok[ch] = 1'b1; ov_ok[ch] = 1'b1; en_in[ch] = 1'b1;
    endtask

    // Brings channel 0 to ON (from N0, ON entered at edge 29) and trips its breaker.
    task automatic up_and_trip0();
        on_pin = 1'b1; raise(0);
        tick(30);
        brk_over[0] = 1'b1; tick(BRK); brk_over[0] = 1'b0;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_tests++; n_fail++;
            $display("FAIL watchdog expired actual=running expected=finished");
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    initial begin
        int mism;
        int unsigned seed;
        seed = 32'h5eed;
        void'($urandom(seed));

        // R1 reset state
        do_reset();
        check("R1 gate", gate_en, 0);
        check("R1 pg", pg_out, 0);
        check("R1 fault", oc_fault, 0);

        // R2 debounce length, R6 start-up window, R7 power-good follow
        on_pin = 1'b1; pg_in = 2'b11; raise(0);
        tick(DEB);   check("R2 gate before debounce end", gate_en[0], 0);
        tick(1);     check("R2 gate at debounce end", gate_en[0], 1);
        tick(START - 1); check("R6 pg hidden in start-up", pg_out[0], 0);
        tick(1);     check("R7 pg after start-up", pg_out[0], 1);
        pg_in[0] = 1'b0; tick(1); check("R7 pg follows input", pg_out[0], 0);

        // R2 dropout restarts debounce
        do_reset(); on_pin = 1'b1; raise(0);
        tick(4); en_in[0] = 1'b0; tick(1); en_in[0] = 1'b1;
        tick(8); check("R2 restarted debounce low", gate_en[0], 0);
        tick(1); check("R2 restarted debounce high", gate_en[0], 1);

        // R3 ON pin and register override
        do_reset(); raise(0);
        tick(15); check("R3 held off by ON low", gate_en[0], 0);
        reg_on_sel[0] = 1'b1; reg_on_val[0] = 1'b1;
        tick(1);  check("R3 register ON starts", gate_en[0], 1);
        reg_on_val[0] = 1'b0;
        tick(1);  check("R3 register OFF stops", gate_en[0], 0);
        on_pin = 1'b1;
        tick(5);  check("R3 register overrides high pin", gate_en[0], 0);
        reg_on_sel[0] = 1'b0;
        tick(5);  check("R3 pin control restored", gate_en[0], 1);

        // R6 start-up fault
        do_reset(); on_pin = 1'b1; ilim_act[0] = 1'b1; raise(0);
        tick(DEB + START); check("R6 gate on at window end", gate_en[0], 1);
        tick(1); check("R6 gate off after limit fault", gate_en[0], 0);
        check("R6 fault flag", oc_fault[0], 1);

        // R7 breaker timeout, directed 3 and 4 then random burst lengths
        for (int it = 0; it < 8; it++) begin
            int k;
            k = (it == 0) ? BRK - 1 : (it == 1) ? BRK : 1 + int'($urandom % 7);
            do_reset(); on_pin = 1'b1; raise(0);
            tick(30);
            brk_over[0] = 1'b1; tick(k); brk_over[0] = 1'b0; tick(1);
            check("R7 breaker fault", oc_fault[0], exp_trip(k));
            check("R7 breaker gate", gate_en[0], 1 - exp_trip(k));
        end

        // R4 independent late arrival restarts debounce
        do_reset(); on_pin = 1'b1; raise(0);
        tick(4); raise(1);
        mism = 0;
        for (int c = 0; c < 20; c++) begin
            tick(1);
            if (gate_en[0] != gate_en[1]) mism++;
        end
        check("R4 gates rise together", mism, 0);
        check("R4 both on", gate_en, 3);

        // R5 blocked during other's start-up, R9 fault isolation
        do_reset(); on_pin = 1'b1; raise(0);
        tick(10); raise(1);
        tick(15); check("R5 blocked during start-up", gate_en[1], 0);
        tick(6);  check("R5 starts after start-up", gate_en[1], 1);
        brk_over[0] = 1'b1; tick(BRK); brk_over[0] = 1'b0; tick(1);
        check("R9 faulted channel off", gate_en[0], 0);
        check("R9 other channel stays on", gate_en[1], 1);

        // R10 cool-down blocks both, then retry
        do_reset(); retry_en = 2'b01;
        up_and_trip0();
        raise(1);
        tick(COOL - 10); check("R10 no start in cool-down", gate_en, 0);
        tick(DEB + 25);  check("R10 restart after cool-down", gate_en, 3);

        // R11 enable cycling no bypass, ON cycling bypasses
        do_reset();
        up_and_trip0();
        en_in[0] = 1'b0; tick(3); en_in[0] = 1'b1;
        tick(100); check("R11 enable cycle no bypass", gate_en[0], 0);
        on_pin = 1'b0; tick(2); on_pin = 1'b1;
        tick(DEB + 6); check("R11 ON cycle bypass", gate_en[0], 1);
        check("R11 fault cleared", oc_fault[0], 0);

        // R12 latched off
        do_reset();
        up_and_trip0();
        tick(COOL + DEB + 30); check("R12 latched gate", gate_en[0], 0);
        check("R12 latched flag", oc_fault[0], 1);
        en_in[0] = 1'b0; tick(2); en_in[0] = 1'b1;
        tick(20); check("R12 enable cycle ignored", gate_en[0], 0);
        on_pin = 1'b0; tick(2); on_pin = 1'b1;
        tick(DEB + 6); check("R12 ON cycle releases", gate_en[0], 1);

        // R8 coupled start and trip
        do_reset(); couple_mode = 1'b1; on_pin = 1'b1; raise(0);
        tick(30); check("R8 waits for partner", gate_en[0], 0);
        raise(1);
        mism = 0;
        for (int c = 0; c < 30; c++) begin
            tick(1);
            if (gate_en[0] != gate_en[1]) mism++;
        end
        check("R8 start together", mism, 0);
        check("R8 both on", gate_en, 3);
        brk_over[0] = 1'b1; tick(BRK); brk_over[0] = 1'b0; tick(1);
        check("R8 both off on trip", gate_en, 0);
        check("R8 only own flag", oc_fault, 1);

        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule